// File: doc/BRIEF.md
# Register-Programmed Memory Copy Engine

This block moves data from one region of a memory-mapped space to another without processor involvement. Software programs a source address, a destination address and a byte count through a small register port. It picks a transfer size and sets a start bit. The engine then alternates single reads and single writes on two master ports. Each read has one cycle of data latency, and each master honours a stall input.

A transfer can finish for any of three reasons, and each reason has its own enable bit. The first is the byte count reaching zero. The second is a flow-controlled source that flags the last value it returns. The third is a flow-controlled destination that flags the last value it accepts. When the transfer finishes, the engine records the reason in its status register and sets a done flag. It can also raise an interrupt, which stays asserted until software writes the status register.

Top module: `dma_copier`

## Requirements
- R1: After reset every register reads zero, `rdRead`, `wrWrite` and `irq` are 0.
- R2: Register offsets are 0 status, 1 source address, 2 destination address, 3 byte count, 6 control. Source address, destination address, byte count and all eight control bits read back what was written. Any other offset reads zero.
- R3: Reads are issued only when three things hold. Control bit 3 (start) must be 1. The last control write must have carried that bit. The byte count must be non-zero. Otherwise no read appears.
- R4: Each value read at the source address is written unchanged to the destination address. At most one value is in flight: a read is issued only after the previous write has been accepted.
- R5: Both addresses advance after each transferred value by the transfer size. The size is 4 if control bit 2 is set, else 2 if bit 1 is set, else 1. This means the largest selected size wins, and no size bits selects 1.
- R6: Each accepted write lowers the byte count by the transfer size, saturating at zero. When the count reaches zero, status bit 4 is set.
- R7: With control bit 7 set, the transfer finishes on the write that brings the count to zero. With bit 7 clear, a zero count stops new reads, but the transfer stays unfinished with status bit 1 (busy) still 1.
- R8: `rdEop` is sampled together with read data. With control bit 5 set, a flagged value is still written, the transfer then finishes, and status bit 2 is set. With bit 5 clear, the flag is ignored.
- R9: `wrEop` is sampled when a write is accepted. With control bit 6 set, that write finishes the transfer and status bit 3 is set. With bit 6 clear, the flag is ignored.
- R10: While `rdWait` is 1, `rdRead` and `rdAddr` hold. While `wrWait` is 1, `wrWrite`, `wrAddr` and `wrData` hold.
- R11: Busy (status bit 1) rises with the first read and falls when the transfer finishes. At the same moment done (status bit 0) is set. After that, no read is issued until a new control write carries the start bit.
- R12: `irq` is 1 exactly while done is 1 and control bit 4 is 1. Any write to the status register clears status bits 0, 2, 3 and 4 and drops `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register offset |
| regWrite | input | 1 | Register write strobe |
| regWdata | input | REG_W | Register write data |
| regRdata | output | REG_W | Register read data, combinational |
| irq | output | 1 | Interrupt request |
| rdAddr | output | ADDR_W | Source byte address |
| rdRead | output | 1 | Read request |
| rdWait | input | 1 | Source stall |
| rdData | input | DATA_W | Read data, valid the cycle after acceptance |
| rdEop | input | 1 | Source last-value flag, valid with rdData |
| wrAddr | output | ADDR_W | Destination byte address |
| wrWrite | output | 1 | Write request |
| wrWait | input | 1 | Destination stall |
| wrData | output | DATA_W | Write data |
| wrEop | input | 1 | Destination last-value flag, sampled on write acceptance |

## Verification
The hardest situations to reach are the ones where end conditions coincide or compete. A source flag may land on the same value that empties the count. A destination flag may arrive while the count-end enable is off. Either can happen while both masters are stalling at random. The stimulus places the source and destination flags at chosen value indices. It mixes every combination of the three end enables and redundant size bits, and it forces a reachable end condition whenever the count-end enable is off. A directed run leaves the count-end enable off with no flags, to show the engine stays busy without issuing further reads.

// File: rtl/dma_copier_pkg.sv
package dma_copier_pkg;

  localparam int CTRL_W = 8;

  localparam logic [2:0] OFF_STATUS  = 3'd0;
  localparam logic [2:0] OFF_RDADDR  = 3'd1;
  localparam logic [2:0] OFF_WRADDR  = 3'd2;
  localparam logic [2:0] OFF_LENGTH  = 3'd3;
  localparam logic [2:0] OFF_CONTROL = 3'd6;

  localparam int CB_BYTE   = 0;
  localparam int CB_HALF   = 1;
  localparam int CB_WORD   = 2;
  localparam int CB_GO     = 3;
  localparam int CB_IRQEN  = 4;
  localparam int CB_RDEOP  = 5;
  localparam int CB_WREOP  = 6;
  localparam int CB_LENEND = 7;

  localparam int SB_DONE = 0;
  localparam int SB_BUSY = 1;
  localparam int SB_REOP = 2;
  localparam int SB_WEOP = 3;
  localparam int SB_LEN  = 4;
  localparam int STAT_W  = 5;

  typedef struct packed {
    logic startRead;
    logic capture;
    logic advance;
    logic finish;
    logic endByRead;
    logic endByWrite;
  } dmaStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_CAPTURE,
    ST_WRITE
  } dmaState_e;

endpackage

// File: rtl/dma_copier_addr_ctr.sv
module dma_copier_addr_ctr #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [ADDR_W-1:0] loadVal,
  input  logic              advance,
  input  logic [2:0]        stepBytes,
  output logic [ADDR_W-1:0] addr
);

  // software load takes priority over the engine's own advance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr <= '0;
    end else if (load) begin
      addr <= loadVal;
    end else if (advance) begin
      addr <= addr + ADDR_W'(stepBytes);
    end
  end

endmodule

// File: rtl/dma_copier_datapath.sv
module dma_copier_datapath
  import dma_copier_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 32,
  parameter int REG_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         regAddr,
  input  logic               regWrite,
  input  logic [REG_W-1:0]   regWdata,
  output logic [REG_W-1:0]   regRdata,
  input  dmaStrobe_t         strobe,
  input  logic [DATA_W-1:0]  rdData,
  input  logic               rdEop,
  output logic [ADDR_W-1:0]  rdAddr,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [DATA_W-1:0]  wrData,
  output logic [CTRL_W-1:0]  ctrlBits,
  output logic [STAT_W-1:0]  statusBits,
  output logic [LEN_W-1:0]   lenVal,
  output logic               canIssue,
  output logic               lenLastStep,
  output logic               eopHeld,
  output logic               irq
);

  localparam int NUM_CH = 2;

  logic [CTRL_W-1:0] ctrlReg;
  logic [LEN_W-1:0]  lenReg;
  logic [DATA_W-1:0] dataHold;
  logic              eopHold;
  logic              armed;
  logic              busyFlag, doneFlag, reopFlag, weopFlag, lenFlag;
  logic [2:0]        stepBytes;
  logic              wrStatus, wrLength, wrControl;
  logic [NUM_CH-1:0] chLoad;
  logic [ADDR_W-1:0] chAddr [NUM_CH];

  assign wrStatus  = regWrite && (regAddr == OFF_STATUS);
  assign wrLength  = regWrite && (regAddr == OFF_LENGTH);
  assign wrControl = regWrite && (regAddr == OFF_CONTROL);
  assign chLoad[0] = regWrite && (regAddr == OFF_RDADDR);
  assign chLoad[1] = regWrite && (regAddr == OFF_WRADDR);

  // largest selected size wins; nothing selected means single bytes
  always_comb begin
    if (ctrlReg[CB_WORD])      stepBytes = 3'd4;
    else if (ctrlReg[CB_HALF]) stepBytes = 3'd2;
    else                       stepBytes = 3'd1;
  end

  assign lenLastStep = (lenReg <= LEN_W'(stepBytes));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_addr
    dma_copier_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk      (clk),
      .rstN     (rstN),
      .load     (chLoad[ch]),
      .loadVal  (regWdata[ADDR_W-1:0]),
      .advance  (strobe.advance),
      .stepBytes(stepBytes),
      .addr     (chAddr[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      lenReg   <= '0;
      dataHold <= '0;
      eopHold  <= 1'b0;
      armed    <= 1'b0;
      busyFlag <= 1'b0;
      doneFlag <= 1'b0;
      reopFlag <= 1'b0;
      weopFlag <= 1'b0;
      lenFlag  <= 1'b0;
    end else begin
      if (wrControl) ctrlReg <= regWdata[CTRL_W-1:0];

      if (wrControl)          armed <= regWdata[CB_GO];
      else if (strobe.finish) armed <= 1'b0;

      if (wrLength)            lenReg <= regWdata[LEN_W-1:0];
      else if (strobe.advance) lenReg <= lenLastStep ? '0 : lenReg - LEN_W'(stepBytes);

      if (strobe.capture) begin
        dataHold <= rdData;
        eopHold  <= rdEop;
      end

      if (strobe.finish)         busyFlag <= 1'b0;
      else if (strobe.startRead) busyFlag <= 1'b1;

      if (strobe.finish) doneFlag <= 1'b1;
      else if (wrStatus) doneFlag <= 1'b0;

      if (strobe.finish && strobe.endByRead) reopFlag <= 1'b1;
      else if (wrStatus)                     reopFlag <= 1'b0;

      if (strobe.finish && strobe.endByWrite) weopFlag <= 1'b1;
      else if (wrStatus)                      weopFlag <= 1'b0;

      if (strobe.advance && lenLastStep) lenFlag <= 1'b1;
      else if (wrStatus)                 lenFlag <= 1'b0;
    end
  end

  always_comb begin
    case (regAddr)
      OFF_STATUS:  regRdata = REG_W'(statusBits);
      OFF_RDADDR:  regRdata = REG_W'(chAddr[0]);
      OFF_WRADDR:  regRdata = REG_W'(chAddr[1]);
      OFF_LENGTH:  regRdata = REG_W'(lenReg);
      OFF_CONTROL: regRdata = REG_W'(ctrlReg);
      default:     regRdata = '0;
    endcase
  end

  assign statusBits = {lenFlag, weopFlag, reopFlag, busyFlag, doneFlag};
  assign rdAddr     = chAddr[0];
  assign wrAddr     = chAddr[1];
  assign wrData     = dataHold;
  assign eopHeld    = eopHold;
  assign ctrlBits   = ctrlReg;
  assign lenVal     = lenReg;
  assign canIssue   = armed && ctrlReg[CB_GO] && (lenReg != '0);
  assign irq        = ctrlReg[CB_IRQEN] && doneFlag;

endmodule

// File: rtl/dma_copier_control.sv
module dma_copier_control
  import dma_copier_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       canIssue,
  input  logic       rdWait,
  input  logic       wrWait,
  input  logic       wrEop,
  input  logic       eopHeld,
  input  logic       lenLastStep,
  input  logic       endOnLen,
  input  logic       endOnRdEop,
  input  logic       endOnWrEop,
  output logic       rdRead,
  output logic       wrWrite,
  output dmaStrobe_t strobe
);

  dmaState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (canIssue) begin
          strobe.startRead = 1'b1;
          stateNext        = ST_READ;
        end
      end
      ST_READ: begin
        if (!rdWait) stateNext = ST_CAPTURE;
      end
      ST_CAPTURE: begin
        strobe.capture = 1'b1;
        stateNext      = ST_WRITE;
      end
      ST_WRITE: begin
        if (!wrWait) begin
          strobe.advance    = 1'b1;
          strobe.endByRead  = endOnRdEop && eopHeld;
          strobe.endByWrite = endOnWrEop && wrEop;
          strobe.finish     = strobe.endByRead || strobe.endByWrite ||
                              (endOnLen && lenLastStep);
          stateNext         = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign rdRead  = (state == ST_READ);
  assign wrWrite = (state == ST_WRITE);

endmodule

// File: rtl/dma_copier.sv
module dma_copier
  import dma_copier_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 32,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regAddr,
  input  logic              regWrite,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic              irq,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdRead,
  input  logic              rdWait,
  input  logic [DATA_W-1:0] rdData,
  input  logic              rdEop,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              wrWrite,
  input  logic              wrWait,
  output logic [DATA_W-1:0] wrData,
  input  logic              wrEop
);

  dmaStrobe_t        strobe;
  logic [CTRL_W-1:0] ctrlBits;
  logic [STAT_W-1:0] statusBits;
  logic [LEN_W-1:0]  lenVal;
  logic              canIssue, lenLastStep, eopHeld;

  dma_copier_datapath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .REG_W(REG_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWrite   (regWrite),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .strobe     (strobe),
    .rdData     (rdData),
    .rdEop      (rdEop),
    .rdAddr     (rdAddr),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .ctrlBits   (ctrlBits),
    .statusBits (statusBits),
    .lenVal     (lenVal),
    .canIssue   (canIssue),
    .lenLastStep(lenLastStep),
    .eopHeld    (eopHeld),
    .irq        (irq)
  );

  dma_copier_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .canIssue   (canIssue),
    .rdWait     (rdWait),
    .wrWait     (wrWait),
    .wrEop      (wrEop),
    .eopHeld    (eopHeld),
    .lenLastStep(lenLastStep),
    .endOnLen   (ctrlBits[CB_LENEND]),
    .endOnRdEop (ctrlBits[CB_RDEOP]),
    .endOnWrEop (ctrlBits[CB_WREOP]),
    .rdRead     (rdRead),
    .wrWrite    (wrWrite),
    .strobe     (strobe)
  );

endmodule

// File: rtl/dma_copier_sva.sv
module dma_copier_sva #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        regAddr,
  input logic              regWrite,
  input logic              irq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdRead,
  input logic              rdWait,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              wrWrite,
  input logic              wrWait,
  input logic [DATA_W-1:0] wrData,
  input logic [7:0]        ctrlBits,
  input logic [4:0]        statusBits,
  input logic [LEN_W-1:0]  lenVal
);

  p_read_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdRead && rdWait && !regWrite) |=> (rdRead && $stable(rdAddr)));

  p_write_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrWrite && wrWait && !regWrite) |=> (wrWrite && $stable(wrAddr) && $stable(wrData)));

  p_single_flight_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(rdRead && wrWrite));

  p_go_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdRead) |-> ($past(ctrlBits[3]) && ($past(lenVal) != '0)));

  p_len_no_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrite && regAddr == 3'd3) |=> (lenVal <= $past(lenVal)));

  p_done_source_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusBits[0]) |-> $past(wrWrite && !wrWait));

  p_busy_drop_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusBits[0]) |-> !statusBits[1]);

  p_irq_clear_r12: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == 3'd0 && !(wrWrite && !wrWait)) |=> !irq);

endmodule

bind dma_copier dma_copier_sva #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)
) u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrite  (regWrite),
  .irq       (irq),
  .rdAddr    (rdAddr),
  .rdRead    (rdRead),
  .rdWait    (rdWait),
  .wrAddr    (wrAddr),
  .wrWrite   (wrWrite),
  .wrWait    (wrWait),
  .wrData    (wrData),
  .ctrlBits  (ctrlBits),
  .statusBits(statusBits),
  .lenVal    (lenVal)
);

// File: tb/dma_copier_test.sv
module dma_copier_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  regAddr;
  logic        regWrite;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic        irq;
  logic [31:0] rdAddr, wrAddr, rdData, wrData;
  logic        rdRead, rdWait, rdEop, wrWrite, wrWait, wrEop;

  int nChecks = 0;
  int nErrors = 0;
  int rdCount, wrCount, tSz, rEopAt, wEopAt, pendIdx;
  logic [31:0] tRdA, tWrA, pendAddr, prevRdAddr, prevWrAddr, prevWrData;
  bit stallOn, pendRd, prevRdStall, prevWrStall;

  always #5 clk = ~clk;

  dma_copier uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrite(regWrite),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq),
    .rdAddr(rdAddr), .rdRead(rdRead), .rdWait(rdWait), .rdData(rdData),
    .rdEop(rdEop), .wrAddr(wrAddr), .wrWrite(wrWrite), .wrWait(wrWait),
    .wrData(wrData), .wrEop(wrEop)
  );

  function automatic logic [31:0] dataAt(input logic [31:0] a);
    return {a[15:0] ^ 16'hA5C3, ~a[15:0]};
  endfunction

  function automatic int stepOf(input logic [7:0] c);
    if (c[2]) return 4;
    if (c[1]) return 2;
    return 1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrite = 1'b1;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdata;
  endtask

  // memory-side responder: source returns data one cycle after acceptance
  initial begin
    rdWait = 1'b0; wrWait = 1'b0; rdEop = 1'b0; wrEop = 1'b0; rdData = '0;
    pendRd = 1'b0; prevRdStall = 1'b0; prevWrStall = 1'b0;
    forever begin
      @(negedge clk);
      if (pendRd) begin
        rdData = dataAt(pendAddr);
        rdEop  = (pendIdx == rEopAt);
        pendRd = 1'b0;
      end else begin
        rdData = $urandom;
        rdEop  = 1'b0;
      end
      if (prevRdStall) begin
        check("R10 read held", {rdRead, rdAddr[30:0]}, {1'b1, prevRdAddr[30:0]});
      end
      if (prevWrStall) begin
        check("R10 write addr held", {wrWrite, wrAddr[30:0]}, {1'b1, prevWrAddr[30:0]});
        check("R10 write data held", wrData, prevWrData);
      end
      rdWait = stallOn ? 1'($urandom_range(0, 1)) : 1'b0;
      wrWait = stallOn ? 1'($urandom_range(0, 1)) : 1'b0;
      wrEop  = (wrCount == wEopAt);
      if (rdRead && !rdWait) begin
        check("R5 read address", rdAddr, tRdA + 32'(rdCount * tSz));
        check("R4 read after write", 32'(rdCount), 32'(wrCount));
        pendRd = 1'b1; pendAddr = rdAddr; pendIdx = rdCount;
        rdCount++;
      end
      if (wrWrite && !wrWait) begin
        check("R5 write address", wrAddr, tWrA + 32'(wrCount * tSz));
        check("R4 write data", wrData, dataAt(tRdA + 32'(wrCount * tSz)));
        wrCount++;
      end
      prevRdStall = rdRead && rdWait;  prevRdAddr = rdAddr;
      prevWrStall = wrWrite && wrWait; prevWrAddr = wrAddr; prevWrData = wrData;
    end
  end

  task automatic runXfer(input logic [31:0] rA, input logic [31:0] wA, input int len,
                         input logic [7:0] ctl, input int rE, input int wE, input bit stall);
    int sz, nLen, endIdx, writes, lenFinal;
    bit ended;
    logic [31:0] st, v;
    sz = stepOf(ctl);
    nLen = (len + sz - 1) / sz;
    endIdx = 1 << 20;
    if (ctl[7]) endIdx = nLen - 1;
    if (ctl[5] && rE >= 0 && rE < nLen && rE < endIdx) endIdx = rE;
    if (ctl[6] && wE >= 0 && wE < nLen && wE < endIdx) endIdx = wE;
    ended = (endIdx < nLen);
    writes = ended ? endIdx + 1 : nLen;
    lenFinal = len - writes * sz;
    if (lenFinal < 0) lenFinal = 0;

    regWr(3'd6, 32'h0);
    regWr(3'd0, 32'h0);
    regWr(3'd1, rA);
    regWr(3'd2, wA);
    regWr(3'd3, 32'(len));
    tRdA = rA; tWrA = wA; tSz = sz; rEopAt = rE; wEopAt = wE; stallOn = stall;
    rdCount = 0; wrCount = 0;
    regWr(3'd6, {24'h0, ctl | 8'h08});
    for (int c = 0; c < 3000; c++) begin
      regRd(3'd0, st);
      if (ended ? st[0] : (wrCount >= writes)) break;
    end
    if (!ended) repeat (30) @(negedge clk);
    stallOn = 1'b0;
    check("R4 R7 R8 R9 write count", 32'(wrCount), 32'(writes));
    regRd(3'd0, st);
    check("R11 done", 32'(st[0]), 32'(ended));
    check("R7 R11 busy", 32'(st[1]), 32'(!ended));
    check("R8 read-eop status", 32'(st[2]), 32'(ended && ctl[5] && rE == endIdx));
    check("R9 write-eop status", 32'(st[3]), 32'(ended && ctl[6] && wE == endIdx));
    check("R6 zero-count status", 32'(st[4]), 32'(lenFinal == 0));
    regRd(3'd3, v);
    check("R6 remaining count", v, 32'(lenFinal));
    check("R12 irq", 32'(irq), 32'(ended && ctl[4]));
    repeat (15) @(negedge clk);
    check("R11 no further reads", 32'(rdCount), 32'(writes));
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 150000; wd++) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual=%0d expected=<150000 cycles", wd);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED));
    rdCount = 0; wrCount = 0; tSz = 1; tRdA = 0; tWrA = 0;
    rEopAt = -1; wEopAt = -1; stallOn = 1'b0;
    rstN = 1'b0; regAddr = 3'd0; regWrite = 1'b0; regWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      regRd(3'(a), v);
      check("R1 register reset", v, 32'h0);
    end
    check("R1 outputs idle", {29'h0, rdRead, wrWrite, irq}, 32'h0);

    // R2 register map
    regWr(3'd1, 32'h1234_5678);
    regWr(3'd2, 32'h9ABC_DEF0);
    regWr(3'd3, 32'h0000_BEEF);
    regWr(3'd6, 32'h0000_00F7);
    regRd(3'd1, v); check("R2 source address", v, 32'h1234_5678);
    regRd(3'd2, v); check("R2 destination address", v, 32'h9ABC_DEF0);
    regRd(3'd3, v); check("R2 count", v, 32'h0000_BEEF);
    regRd(3'd6, v); check("R2 control", v, 32'h0000_00F7);
    regRd(3'd5, v); check("R2 unmapped", v, 32'h0);
    check("R3 no read without start", 32'(rdCount), 32'h0);
    regWr(3'd6, 32'h0);

    // R3 zero count with start set
    regWr(3'd3, 32'h0);
    rdCount = 0;
    regWr(3'd6, 32'h0000_008C);
    repeat (20) @(negedge clk);
    check("R3 no read with zero count", 32'(rdCount), 32'h0);
    regRd(3'd0, v); check("R3 stays idle", v, 32'h0);
    regWr(3'd6, 32'h0);

    // R4 R5 R6 R7 word copy with irq
    runXfer(32'h0000_1000, 32'h0000_2000, 16, 8'h94, -1, -1, 1'b0);
    // R12 status write drops irq
    regWr(3'd0, 32'h0);
    check("R12 irq cleared", 32'(irq), 32'h0);
    regRd(3'd0, v); check("R12 status cleared", v, 32'h0);

    // R5 largest size wins, none selected is bytes
    runXfer(32'h0000_0100, 32'h0000_0800, 12, 8'h87, -1, -1, 1'b0);
    runXfer(32'h0000_0300, 32'h0000_0900, 5, 8'h80, -1, -1, 1'b0);
    // R6 halfword count not a multiple saturates
    runXfer(32'h0000_0400, 32'h0000_0A00, 5, 8'h82, -1, -1, 1'b0);
    // R7 count end disabled, no flags: stays busy
    runXfer(32'h0000_0500, 32'h0000_0B00, 8, 8'h04, -1, -1, 1'b0);
    // R8 read flag ends, and read flag ignored when disabled
    runXfer(32'h0000_0600, 32'h0000_0C00, 24, 8'hB4, 2, -1, 1'b0);
    runXfer(32'h0000_0600, 32'h0000_0C00, 24, 8'h84, 2, -1, 1'b0);
    // R9 write flag ends, and ignored when disabled
    runXfer(32'h0000_0700, 32'h0000_0D00, 12, 8'h42, 1, 1, 1'b0);
    runXfer(32'h0000_0700, 32'h0000_0D00, 12, 8'h82, -1, 1, 1'b0);
    // R10 stalls on both sides
    runXfer(32'h0000_1F00, 32'h0000_3F00, 32, 8'hF4, 5, 6, 1'b1);

    for (int i = 0; i < 40; i++) begin
      int sel, sz, len, rE, wE, nL;
      logic [7:0] ctl;
      sel = $urandom_range(0, 3);
      ctl = 8'h0;
      if (sel == 1) ctl[0] = 1'b1;
      if (sel == 2) ctl[1:0] = {1'b1, 1'($urandom_range(0, 1))};
      if (sel == 3) ctl[2:0] = {1'b1, 2'($urandom_range(0, 3))};
      ctl[7:4] = 4'($urandom_range(0, 15));
      sz = stepOf(ctl);
      len = $urandom_range(1, 12) * sz;
      nL = len / sz;
      rE = $urandom_range(0, 15);
      wE = $urandom_range(0, 15);
      if (!ctl[7] && !(ctl[5] && rE < nL) && !(ctl[6] && wE < nL)) ctl[7] = 1'b1;
      runXfer($urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC, len, ctl, rE, wE,
              1'($urandom_range(0, 1)));
    end

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule